// File: doc/BRIEF.md
# I2C Command Queue Executor

This block runs the command queues of one I2C master. Software fills either of two word queues (deep queue 0, shallow queue 1) with 32-bit command words, programs how many words to run, then pulses that queue's start bit. The executor walks the queue one word at a time. It decodes a 4-bit opcode in the low nibble of each word and hands single bytes to a byte-level bus engine through a request/response handshake. Read bytes are packed into 32-bit words of a small read buffer, which software drains through a pop port. The block raises pulses for a report, for a finished read and for a no-acknowledge.

The load port and the read-data pop port follow valid/ready rules. A load moves on a cycle with `ld_valid` and `ld_ready` both high. `ld_ready` is held low while the selected queue is full or is being executed, and the source must keep its word stable until it is taken. A pop moves on a cycle with `rdq_valid` and `rdq_ready` both high, and the sink may hold `rdq_ready` low for as long as it needs. While the read buffer is full, the executor stops issuing read requests, so back-pressure reaches the bus engine. Outgoing bus requests stay stable until `bus_req_ready` is seen. The engine answers each accepted request with a single-cycle `bus_rsp_valid`.

Top module: `cmdq_exec`

## Requirements
- R1: A load accepted into queue q is stored at position cur_cnt_q, and cur_cnt_q then rises by one. `ld_ready` is low when the selected queue already holds its depth (64 words for queue 0, 16 words for queue 1) or is being executed, and a refused load changes nothing.
- R2: Bit 2*MASTER_IDX+q of `start_bits` starts queue q only while the executor is idle, and queue 0 wins if both bits are set. Start bits of other masters, and start bits seen while busy, are ignored.
- R3: Execution of queue q consumes exactly the programmed execute count of words, starting at word 0. When the last word is done, cur_cnt_q returns to 0.
- R4: Opcode 1 latches the 7-bit target address from word bits 10:4. Any opcode other than 1, 8, 9 and 10 is skipped as one word.
- R5: Opcode 9 writes N bytes, where N is bits 7:4 of the command byte held in byte 0 of the word. The payload bytes follow that byte in little-endian order through the following words. Each byte is sent as one bus request with `bus_req_rd`=0 and the latched address.
- R6: Opcode 8 pulses `report_irq[q]` for one cycle only when word bit 8 is set.
- R7: Opcode 10 reads N bytes (N in bits 7:4) as N bus requests with `bus_req_rd`=1. It leaves N/4+1 words in the read buffer. Byte 0 of the first word is the non-payload leading byte {address,1}. Data bytes follow little-endian, and unused bytes of the last word are zero. `rd_done` pulses once that last word is stored.
- R8: A response with `bus_rsp_nack`=1 stops execution, discards the remaining words, clears cur_cnt_q and pulses `err_nack`. No report is raised.
- R9: `rdq_valid` is high whenever `rdq_level` is above 0, and a pop removes the oldest word. While the buffer is full, no read request is issued and no word is pushed.
- R10: Only one bus request is outstanding at a time, and a request that is not yet accepted keeps its address, byte and direction stable.
- R11: After reset, both word counts and the read level are 0, `ld_ready` is high, and the bus request and all event outputs are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ld_valid | input | 1 | Load word offered |
| ld_ready | output | 1 | Load word can be taken |
| ld_qsel | input | 1 | Queue targeted by the load |
| ld_data | input | 32 | Command word to load |
| cur_cnt0 | output | CWM | Words held in queue 0 |
| cur_cnt1 | output | CWM | Words held in queue 1 |
| xcnt_we | input | 1 | Write the execute count |
| xcnt_qsel | input | 1 | Queue whose execute count is written |
| xcnt_val | input | CWM | Execute count value |
| start_bits | input | 2*NUM_MASTERS | One-cycle start request, two bits per master |
| bus_req_valid | output | 1 | Byte request to the bus engine |
| bus_req_ready | input | 1 | Bus engine takes the request |
| bus_req_rd | output | 1 | 1 = read a byte, 0 = write a byte |
| bus_req_addr | output | 7 | Target address |
| bus_req_byte | output | 8 | Byte to write |
| bus_rsp_valid | input | 1 | Response for the outstanding request |
| bus_rsp_nack | input | 1 | Target did not acknowledge |
| bus_rsp_byte | input | 8 | Byte read |
| rdq_valid | output | 1 | Read buffer word available |
| rdq_ready | input | 1 | Sink pops the word |
| rdq_data | output | 32 | Oldest read buffer word |
| rdq_level | output | RLW | Words in the read buffer |
| report_irq | output | 2 | Report pulse per queue |
| rd_done | output | 1 | Read completed pulse |
| err_nack | output | 1 | No-acknowledge pulse |

## Verification
A start pulse turns into execution at the next edge, and each decoded word then takes one cycle. Each bus byte costs three cycles with the bench's responder: the request, a one-cycle answer, and the next request. Report and read-done pulses are registered, so they appear the cycle after their word is decoded, and the word count clears one cycle later. The bench therefore samples on falling edges only. It counts event pulses as they happen and compares counts, levels and logged bus bytes after a fixed window that is longer than the worst case. The stall and priority tests sample at points where the awaited effect must already have occurred or must still be held back.

// File: rtl/cmdq_pkg.sv
package cmdq_pkg;
  localparam logic [3:0] OP_SETP   = 4'd1;
  localparam logic [3:0] OP_REPORT = 4'd8;
  localparam logic [3:0] OP_WRITE  = 4'd9;
  localparam logic [3:0] OP_READ   = 4'd10;

  typedef enum logic [2:0] {
    S_IDLE, S_FETCH, S_WREQ, S_WRSP, S_RREQ, S_RRSP, S_RFLUSH
  } seq_state_t;
endpackage

// File: rtl/cmdq_store.sv
module cmdq_store #(
  parameter int DEPTH = 16,
  localparam int CW = $clog2(DEPTH + 1),
  localparam int IW = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ld_en,
  input  logic [31:0]   ld_word,
  input  logic          clr,
  input  logic [IW-1:0] rd_idx,
  output logic [CW-1:0] count,
  output logic          full,
  output logic [31:0]   rd_word
);
  logic [31:0] mem [DEPTH];

  assign full    = (count == CW'(DEPTH));
  assign rd_word = mem[rd_idx];

  always_ff @(posedge clk) begin
    if (ld_en) mem[count[IW-1:0]] <= ld_word;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     count <= '0;
    else if (clr)   count <= '0;
    else if (ld_en) count <= count + 1'b1;
  end

  assert_no_overflow_R1: assert property (@(posedge clk) disable iff (!rst_n)
    ld_en |-> !full);
  assert_clear_quiet_R3: assert property (@(posedge clk) disable iff (!rst_n)
    clr |-> !ld_en);
endmodule

// File: rtl/cmdq_rdbuf.sv
module cmdq_rdbuf #(
  parameter int DEPTH = 4,
  localparam int LW = $clog2(DEPTH + 1),
  localparam int PW = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          push,
  input  logic [31:0]   push_word,
  output logic          full,
  output logic          out_valid,
  input  logic          out_ready,
  output logic [31:0]   out_data,
  output logic [LW-1:0] level
);
  logic [31:0]   mem [DEPTH];
  logic [PW-1:0] wp, rp;
  logic          pop;

  assign full      = (level == LW'(DEPTH));
  assign out_valid = (level != '0);
  assign out_data  = mem[rp];
  assign pop       = out_valid && out_ready;

  function automatic logic [PW-1:0] nxt(input logic [PW-1:0] p);
    return (p == PW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk) begin
    if (push) mem[wp] <= push_word;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp <= '0; rp <= '0; level <= '0;
    end else begin
      if (push) wp <= nxt(wp);
      if (pop)  rp <= nxt(rp);
      level <= level + LW'(push) - LW'(pop);
    end
  end

  assert_no_overflow_R9: assert property (@(posedge clk) disable iff (!rst_n)
    push |-> !full);
endmodule

// File: rtl/cmdq_seq.sv
module cmdq_seq
  import cmdq_pkg::*;
#(
  parameter int CWM = 7
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic [1:0]     go,
  input  logic [CWM-1:0] xlim0,
  input  logic [CWM-1:0] xlim1,
  input  logic [31:0]    word,
  input  logic           buf_full,
  output logic           busy,
  output logic           act_q,
  output logic [CWM-1:0] widx,
  output logic [1:0]     clr,
  output logic           req_valid,
  input  logic           req_ready,
  output logic           req_rd,
  output logic [6:0]     req_addr,
  output logic [7:0]     req_byte,
  input  logic           rsp_valid,
  input  logic           rsp_nack,
  input  logic [7:0]     rsp_byte,
  output logic           push,
  output logic [31:0]    push_word,
  output logic [1:0]     report,
  output logic           rd_done,
  output logic           err
);
  seq_state_t     st;
  logic [CWM-1:0] lim;
  logic [3:0]     rem;
  logic [1:0]     bp;
  logic [31:0]    pack;
  logic           nack_now;

  assign busy     = (st != S_IDLE);
  assign req_rd   = (st == S_RREQ);
  assign req_byte = (st == S_WREQ) ? word[{bp, 3'b000} +: 8] : 8'h00;
  assign req_valid = (st == S_WREQ) || (st == S_RREQ && rem != '0 && !buf_full);
  assign nack_now = (st == S_WRSP || st == S_RRSP) && rsp_valid && rsp_nack;

  always_comb begin
    clr = '0;
    if ((st == S_FETCH && widx == lim) || nack_now) clr[act_q] = 1'b1;
  end

  always_comb begin
    push      = 1'b0;
    push_word = pack;
    if (st == S_RRSP && rsp_valid && !rsp_nack && bp == 2'd3) begin
      push      = 1'b1;
      push_word = {rsp_byte, pack[23:0]};
    end else if (st == S_RFLUSH && bp != 2'd0 && !buf_full) begin
      push = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= S_IDLE; act_q <= 1'b0; widx <= '0; lim <= '0; req_addr <= '0;
      rem <= '0; bp <= '0; pack <= '0; report <= '0; rd_done <= 1'b0; err <= 1'b0;
    end else begin
      report  <= '0;
      rd_done <= 1'b0;
      err     <= 1'b0;
      unique case (st)
        S_IDLE: begin
          widx <= '0;
          if (go[0]) begin
            act_q <= 1'b0; lim <= xlim0; st <= S_FETCH;
          end else if (go[1]) begin
            act_q <= 1'b1; lim <= xlim1; st <= S_FETCH;
          end
        end
        S_FETCH: begin
          if (widx == lim) st <= S_IDLE;
          else begin
            case (word[3:0])
              OP_SETP: begin req_addr <= word[10:4]; widx <= widx + 1'b1; end
              OP_REPORT: begin
                if (word[8]) report[act_q] <= 1'b1;
                widx <= widx + 1'b1;
              end
              OP_WRITE: begin
                rem <= word[7:4];
                bp  <= 2'd1;
                if (word[7:4] == '0) widx <= widx + 1'b1;
                else st <= S_WREQ;
              end
              OP_READ: begin
                rem  <= word[7:4];
                bp   <= 2'd1;
                pack <= {24'h0, req_addr, 1'b1};
                widx <= widx + 1'b1;
                st   <= S_RREQ;
              end
              default: widx <= widx + 1'b1;
            endcase
          end
        end
        S_WREQ: if (req_ready) st <= S_WRSP;
        S_WRSP: begin
          if (rsp_valid) begin
            if (rsp_nack) begin
              err <= 1'b1; st <= S_IDLE;
            end else begin
              rem <= rem - 1'b1;
              bp  <= bp + 1'b1;
              if (bp == 2'd3 || rem == 4'd1) widx <= widx + 1'b1;
              st <= (rem == 4'd1) ? S_FETCH : S_WREQ;
            end
          end
        end
        S_RREQ: begin
          if (rem == '0) st <= S_RFLUSH;
          else if (req_valid && req_ready) st <= S_RRSP;
        end
        S_RRSP: begin
          if (rsp_valid) begin
            if (rsp_nack) begin
              err <= 1'b1; st <= S_IDLE;
            end else begin
              pack[{bp, 3'b000} +: 8] <= rsp_byte;
              if (bp == 2'd3) pack <= '0;
              bp  <= bp + 1'b1;
              rem <= rem - 1'b1;
              st  <= S_RREQ;
            end
          end
        end
        S_RFLUSH: begin
          if (bp == 2'd0 || !buf_full) begin
            rd_done <= 1'b1; bp <= 2'd0; st <= S_FETCH;
          end
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  assert_req_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && !req_ready |=> req_valid && $stable(req_addr) && $stable(req_byte) && $stable(req_rd));
  assert_one_outstanding_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_WRSP || st == S_RRSP) |-> !req_valid);
  assert_clear_ends_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (|clr) |=> !busy);
  assert_err_stops_R8: assert property (@(posedge clk) disable iff (!rst_n)
    err |-> !busy && report == '0);
  assert_stall_full_R9: assert property (@(posedge clk) disable iff (!rst_n)
    buf_full && req_rd |-> !req_valid);
endmodule

// File: rtl/cmdq_exec.sv
module cmdq_exec #(
  parameter int Q0_DEPTH    = 64,
  parameter int Q1_DEPTH    = 16,
  parameter int RD_DEPTH    = 4,
  parameter int NUM_MASTERS = 2,
  parameter int MASTER_IDX  = 0,
  localparam int CW0 = $clog2(Q0_DEPTH + 1),
  localparam int CW1 = $clog2(Q1_DEPTH + 1),
  localparam int CWM = (CW0 > CW1) ? CW0 : CW1,
  localparam int RLW = $clog2(RD_DEPTH + 1)
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     ld_valid,
  output logic                     ld_ready,
  input  logic                     ld_qsel,
  input  logic [31:0]              ld_data,
  output logic [CWM-1:0]           cur_cnt0,
  output logic [CWM-1:0]           cur_cnt1,
  input  logic                     xcnt_we,
  input  logic                     xcnt_qsel,
  input  logic [CWM-1:0]           xcnt_val,
  input  logic [2*NUM_MASTERS-1:0] start_bits,
  output logic                     bus_req_valid,
  input  logic                     bus_req_ready,
  output logic                     bus_req_rd,
  output logic [6:0]               bus_req_addr,
  output logic [7:0]               bus_req_byte,
  input  logic                     bus_rsp_valid,
  input  logic                     bus_rsp_nack,
  input  logic [7:0]               bus_rsp_byte,
  output logic                     rdq_valid,
  input  logic                     rdq_ready,
  output logic [31:0]              rdq_data,
  output logic [RLW-1:0]           rdq_level,
  output logic [1:0]               report_irq,
  output logic                     rd_done,
  output logic                     err_nack
);
  logic [CWM-1:0] q_cnt [2];
  logic [31:0]    q_word [2];
  logic [CWM-1:0] xlim [2];
  logic [1:0]     q_full, ld_en, seq_clr;
  logic           seq_busy, seq_q, buf_full, push;
  logic [CWM-1:0] seq_widx;
  logic [31:0]    push_word;

  assign ld_ready = !q_full[ld_qsel] && !(seq_busy && seq_q == ld_qsel);
  assign cur_cnt0 = q_cnt[0];
  assign cur_cnt1 = q_cnt[1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      xlim[0] <= '0; xlim[1] <= '0;
    end else if (xcnt_we) begin
      xlim[xcnt_qsel] <= xcnt_val;
    end
  end

  for (genvar g = 0; g < 2; g++) begin : g_q
    localparam int D   = (g == 0) ? Q0_DEPTH : Q1_DEPTH;
    localparam int CWG = $clog2(D + 1);
    localparam int IWG = $clog2(D);
    logic [CWG-1:0] cnt_g;
    assign ld_en[g] = ld_valid && ld_ready && (ld_qsel == 1'(g));
    cmdq_store #(.DEPTH(D)) u_store (
      .clk(clk), .rst_n(rst_n), .ld_en(ld_en[g]), .ld_word(ld_data),
      .clr(seq_clr[g]), .rd_idx(seq_widx[IWG-1:0]), .count(cnt_g),
      .full(q_full[g]), .rd_word(q_word[g])
    );
    assign q_cnt[g] = CWM'(cnt_g);
  end

  cmdq_seq #(.CWM(CWM)) u_seq (
    .clk(clk), .rst_n(rst_n), .go(start_bits[2*MASTER_IDX +: 2]),
    .xlim0(xlim[0]), .xlim1(xlim[1]), .word(q_word[seq_q]), .buf_full(buf_full),
    .busy(seq_busy), .act_q(seq_q), .widx(seq_widx), .clr(seq_clr),
    .req_valid(bus_req_valid), .req_ready(bus_req_ready), .req_rd(bus_req_rd),
    .req_addr(bus_req_addr), .req_byte(bus_req_byte),
    .rsp_valid(bus_rsp_valid), .rsp_nack(bus_rsp_nack), .rsp_byte(bus_rsp_byte),
    .push(push), .push_word(push_word), .report(report_irq),
    .rd_done(rd_done), .err(err_nack)
  );

  cmdq_rdbuf #(.DEPTH(RD_DEPTH)) u_rdbuf (
    .clk(clk), .rst_n(rst_n), .push(push), .push_word(push_word), .full(buf_full),
    .out_valid(rdq_valid), .out_ready(rdq_ready), .out_data(rdq_data), .level(rdq_level)
  );
endmodule

// File: tb/cmdq_exec_test.sv
module cmdq_exec_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        ld_valid = 1'b0, ld_qsel = 1'b0, xcnt_we = 1'b0, xcnt_qsel = 1'b0;
  logic [31:0] ld_data = '0;
  logic [6:0]  xcnt_val = '0;
  logic [3:0]  start_bits = '0;
  logic        bus_req_ready = 1'b1, bus_rsp_valid = 1'b0, bus_rsp_nack = 1'b0;
  logic [7:0]  bus_rsp_byte = '0;
  logic        rdq_ready = 1'b0;
  logic        ld_ready, bus_req_valid, bus_req_rd, rdq_valid, rd_done, err_nack;
  logic [6:0]  cur_cnt0, cur_cnt1, bus_req_addr;
  logic [7:0]  bus_req_byte;
  logic [31:0] rdq_data;
  logic [2:0]  rdq_level;
  logic [1:0]  report_irq;

  cmdq_exec uut (.*);

  always #5 clk = ~clk;

  int total = 0, bad = 0;
  int n_rep0 = 0, n_rep1 = 0, n_rdd = 0, n_err = 0, n_req = 0, n_rd = 0, n_proto = 0;
  logic [7:0] lg_b [16];
  logic [6:0] lg_a [16];
  logic       lg_r [16];
  bit         pend = 1'b0;
  logic [6:0] pend_a;

  // Bus engine model and event counters, all on falling edges.
  always @(negedge clk) begin
    if (report_irq[0]) n_rep0++;
    if (report_irq[1]) n_rep1++;
    if (rd_done) n_rdd++;
    if (err_nack) n_err++;
    bus_rsp_valid = 1'b0;
    bus_rsp_nack  = 1'b0;
    if (pend) begin
      if (bus_req_valid) n_proto++;
      bus_rsp_valid = 1'b1;
      bus_rsp_nack  = (pend_a == 7'h55);
      bus_rsp_byte  = 8'h30 + 8'(n_rd - 1);
      pend = 1'b0;
    end else if (bus_req_valid && bus_req_ready) begin
      if (n_req < 16) begin
        lg_b[n_req] = bus_req_byte; lg_a[n_req] = bus_req_addr; lg_r[n_req] = bus_req_rd;
      end
      if (bus_req_rd) n_rd++;
      n_req++;
      pend = 1'b1;
      pend_a = bus_req_addr;
    end
  end

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic load(input logic q, input logic [31:0] w);
    @(negedge clk);
    ld_valid = 1'b1; ld_qsel = q; ld_data = w;
    @(negedge clk);
    ld_valid = 1'b0;
  endtask

  task automatic set_exec(input logic q, input int n);
    @(negedge clk);
    xcnt_we = 1'b1; xcnt_qsel = q; xcnt_val = 7'(n);
    @(negedge clk);
    xcnt_we = 1'b0;
  endtask

  task automatic go(input logic [3:0] b);
    @(negedge clk);
    start_bits = b;
    @(negedge clk);
    start_bits = '0;
  endtask

  task automatic clear_logs();
    n_rep0 = 0; n_rep1 = 0; n_rdd = 0; n_err = 0; n_req = 0; n_rd = 0;
  endtask

  task automatic pop(output logic [31:0] w);
    @(negedge clk);
    w = rdq_data;
    rdq_ready = 1'b1;
    @(negedge clk);
    rdq_ready = 1'b0;
  endtask

  function automatic logic [7:0] pl(input int addr, input int i);
    return 8'(i * 29 + addr);
  endfunction

  function automatic logic [31:0] rexp(input int addr, input int len, input int w);
    logic [31:0] r = '0;
    for (int k = 0; k < 4; k++) begin
      int i = 4 * w + k;
      logic [7:0] b = '0;
      if (i == 0) b = {7'(addr), 1'b1};
      else if (i <= len) b = 8'h30 + 8'(i - 1);
      r[8*k +: 8] = b;
    end
    return r;
  endfunction

  // {read, queue, addr[6:0], len[3:0]}
  localparam logic [12:0] VEC [8] = '{
    {1'b0, 1'b0, 7'h12, 4'd0},
    {1'b0, 1'b0, 7'h12, 4'd3},
    {1'b0, 1'b0, 7'h21, 4'd11},
    {1'b0, 1'b1, 7'h33, 4'd4},
    {1'b1, 1'b1, 7'h40, 4'd0},
    {1'b1, 1'b1, 7'h41, 4'd3},
    {1'b1, 1'b0, 7'h42, 4'd4},
    {1'b1, 1'b1, 7'h43, 4'd12}
  };

  initial begin
    repeat (150000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog R11 actual=%0h expected=%0h", 1, 0);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [31:0] w;
    cyc(3);
    rst_n = 1'b1;
    cyc(2);
    // R11 reset state
    check(ld_ready == 1'b1, "R11 ld_ready", ld_ready, 1);
    check(cur_cnt0 == 0 && cur_cnt1 == 0, "R11 counts", cur_cnt0 + cur_cnt1, 0);
    check(rdq_level == 0 && !rdq_valid, "R11 rdq", rdq_level, 0);
    check(!bus_req_valid && report_irq == 0 && !rd_done && !err_nack, "R11 outputs", bus_req_valid, 0);

    // Vector table: writes and reads
    for (int v = 0; v < 8; v++) begin
      logic rd = VEC[v][12];
      logic q  = VEC[v][11];
      int addr = int'(VEC[v][10:4]);
      int len  = int'(VEC[v][3:0]);
      int nw, nex;
      clear_logs();
      load(q, {21'h0, 7'(addr), 4'h1});
      if (!rd) begin
        logic [7:0] by [16];
        nw = (len + 4) / 4;
        by[0] = {4'(len), 4'h9};
        for (int i = 1; i < 16; i++) by[i] = (i <= len) ? pl(addr, i - 1) : 8'h00;
        for (int k = 0; k < nw; k++) load(q, {by[4*k+3], by[4*k+2], by[4*k+1], by[4*k]});
        load(q, 32'h0000_0108);
        nex = nw + 2;
      end else begin
        load(q, {24'h0, 4'(len), 4'hA});
        nex = 2;
      end
      check((q ? cur_cnt1 : cur_cnt0) == 7'(nex), "R1 count after loads",
            q ? cur_cnt1 : cur_cnt0, nex);
      set_exec(q, nex);
      go(q ? 4'b0010 : 4'b0001);
      cyc(80);
      check((q ? cur_cnt1 : cur_cnt0) == 0, "R3 count cleared", q ? cur_cnt1 : cur_cnt0, 0);
      check(n_err == 0, "R8 no error", n_err, 0);
      if (!rd) begin
        check(n_req == len, "R5 write byte count", n_req, len);
        for (int i = 0; i < len; i++) begin
          check(lg_b[i] == pl(addr, i) && !lg_r[i], "R5 write byte", lg_b[i], pl(addr, i));
          check(lg_a[i] == 7'(addr), "R4 address", lg_a[i], addr);
        end
        check((q ? n_rep1 : n_rep0) == 1, "R6 report raised", q ? n_rep1 : n_rep0, 1);
      end else begin
        check(n_rd == len, "R7 read requests", n_rd, len);
        check(n_rdd == 1, "R7 rd_done", n_rdd, 1);
        check(int'(rdq_level) == len / 4 + 1, "R7 level", rdq_level, len / 4 + 1);
        for (int k = 0; k < len / 4 + 1; k++) begin
          check(rdq_valid == 1'b1, "R9 valid with data", rdq_valid, 1);
          pop(w);
          check(w == rexp(addr, len, k), "R7 packed word", w, rexp(addr, len, k));
        end
        check(rdq_level == 0 && !rdq_valid, "R9 drained", rdq_level, 0);
      end
    end

    // R1 full queue, R4 unknown opcode skip, R6 report without bit 8
    clear_logs();
    for (int i = 0; i < 16; i++) load(1'b1, (i % 2 == 0) ? 32'h0000_0000 : 32'h0000_0008);
    check(cur_cnt1 == 16, "R1 queue full count", cur_cnt1, 16);
    @(negedge clk);
    ld_valid = 1'b1; ld_qsel = 1'b1; ld_data = 32'h0000_0108;
    cyc(0);
    check(ld_ready == 1'b0, "R1 ready low when full", ld_ready, 0);
    @(negedge clk);
    ld_valid = 1'b0;
    check(cur_cnt1 == 16, "R1 refused load", cur_cnt1, 16);
    set_exec(1'b1, 16);
    go(4'b0010);
    cyc(40);
    check(cur_cnt1 == 0, "R3 cleared after 16", cur_cnt1, 0);
    check(n_rep1 == 0, "R6 no report without bit 8", n_rep1, 0);
    check(n_req == 0, "R4 skipped opcodes no traffic", n_req, 0);

    // R2 foreign start bit ignored, then priority
    clear_logs();
    load(1'b0, 32'h0000_0108);
    load(1'b1, 32'h0000_0108);
    set_exec(1'b0, 1);
    set_exec(1'b1, 1);
    go(4'b0100);
    cyc(10);
    check(n_rep0 == 0 && cur_cnt0 == 1, "R2 other master ignored", cur_cnt0, 1);
    go(4'b0011);
    cyc(20);
    check(n_rep0 == 1 && cur_cnt0 == 0, "R2 queue 0 wins", n_rep0, 1);
    check(n_rep1 == 0 && cur_cnt1 == 1, "R2 queue 1 dropped", cur_cnt1, 1);
    go(4'b0010);
    cyc(20);
    check(n_rep1 == 1 && cur_cnt1 == 0, "R2 queue 1 started alone", n_rep1, 1);

    // R8 no-acknowledge stops the queue
    clear_logs();
    load(1'b0, {21'h0, 7'h55, 4'h1});
    load(1'b0, {8'h00, 8'hBB, 8'hAA, 8'h29});
    load(1'b0, 32'h0000_0108);
    set_exec(1'b0, 3);
    go(4'b0001);
    cyc(40);
    check(n_err == 1, "R8 error pulse", n_err, 1);
    check(n_rep0 == 0, "R8 no report", n_rep0, 0);
    check(cur_cnt0 == 0, "R8 count cleared", cur_cnt0, 0);
    check(n_req == 1, "R8 stopped after nack", n_req, 1);

    // R9 read buffer back-pressure
    clear_logs();
    load(1'b1, {21'h0, 7'h44, 4'h1});
    load(1'b1, 32'h0000_00CA);
    set_exec(1'b1, 2);
    go(4'b0010);
    cyc(80);
    check(rdq_level == 4, "R9 buffer full", rdq_level, 4);
    load(1'b1, {21'h0, 7'h44, 4'h1});
    load(1'b1, 32'h0000_000A);
    set_exec(1'b1, 2);
    go(4'b0010);
    cyc(30);
    check(n_rdd == 1, "R9 second read held", n_rdd, 1);
    check(cur_cnt1 == 2, "R9 queue still running", cur_cnt1, 2);
    pop(w);
    check(w == rexp(7'h44, 12, 0), "R9 first word", w, rexp(7'h44, 12, 0));
    cyc(5);
    check(n_rdd == 2 && cur_cnt1 == 0, "R9 released after pop", n_rdd, 2);
    check(rdq_level == 4, "R9 level refilled", rdq_level, 4);
    for (int k = 1; k < 4; k++) begin
      pop(w);
      check(w == rexp(7'h44, 12, k), "R9 remaining word", w, rexp(7'h44, 12, k));
    end
    pop(w);
    check(w == rexp(7'h44, 0, 0), "R9 second read word", w, rexp(7'h44, 0, 0));

    check(n_proto == 0, "R10 one outstanding request", n_proto, 0);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule